// File: doc/BRIEF.md
# Shared-Pin Parallel I/O Port

This block is a small general-purpose parallel port for a microcontroller's register bus. It serves `NB` bidirectional pins (four by default, two in the reduced variant), one pin that can only drive and one pin that can only sense. Software reaches a data latch, a direction bit and a pull-enable bit for each pin through a synchronous register interface. Each sensed pin passes through a two-stage synchronizer on the bus clock before software or a peripheral can see it.

Peripherals and analog functions can take over individual bidirectional pins. An analog function has the highest priority. It silences the pin's driver, its pull and its input. A digital peripheral comes next and supplies its own output enable and output data. Only when neither is active does the port's own direction bit and latch drive the pin. The output-only pin leaves reset under the control of a debug/mode function. A two-state ownership machine (`OO_DEBUG`, `OO_PORT`) hands it to the port's latch. The transition *claim* (`OO_DEBUG` to `OO_PORT`) occurs on a control-register write with bit 0 set. The transition *release* (`OO_PORT` to `OO_DEBUG`) occurs on a control-register write with bit 0 clear. Any other cycle holds the state.

Register map (`bus_addr`): 0 = data, 1 = direction, 2 = pull enable, 3 = control (bit 0 = output-only pin owned by the port). Bit positions in the data, direction and pull registers are the same. Bits 0..NB-1 are the bidirectional pins, bit NB is the input-only pin, bit NB+1 is the output-only pin, and higher bits read 0. Reads are combinational. Writes take effect at the clock edge where `bus_we` is high.

Top module: `sharedpin_port`

## Requirements
- R1: After reset the direction bits of the bidirectional pins read 0, all pull-enable bits read 0, the control register reads 0 (state `OO_DEBUG`), and no bidirectional or input-only pin is driven.
- R2: A bidirectional pin with direction bit 1 and no analog or peripheral owner has `pad_oe` = 1 and `pad_out` equal to its latch bit.
- R3: A data-register read returns, for each bidirectional pin, its latch bit when its direction bit is 1 and its synchronized pad input when it is 0. The input-only bit (NB) always returns its synchronized input, and bit NB+1 returns the output-only latch.
- R4: A pad input change appears in data reads and on `pin_in` after exactly two rising clock edges, and not after one.
- R5: Data writes update the latch while the pin is an input. The written value drives the pin as soon as the direction bit is set.
- R6: While `periph_en[i]` is 1 and `analog_en[i]` is 0, `pad_oe[i]` equals `periph_oe[i]` and `pad_out[i]` equals `periph_out[i]`, whatever the port registers hold or are written with.
- R7: While `analog_en[i]` is 1, pin i's data-read bit, `pad_oe`, `pad_pull` and `pin_in` bits are 0, even when a peripheral is enabled on it.
- R8: The direction bit of the input-only pin reads 0 and that of the output-only pin reads 1, whatever is written. The input-only pin is never driven.
- R9: In `OO_DEBUG` the output-only pin follows `dbg_oe`/`dbg_out`. In `OO_PORT` it is always driven with its latch bit. Claim and release follow control writes as stated above, and the control register reads back the state.
- R10: `pad_pull` of a pin is its pull-enable bit gated off while that pin is driven or analog-owned. The output-only pin's pull bit reads 0 and ignores writes.
- R11: `pin_in` gives peripherals the synchronized input of the bidirectional and input-only pins. The output-only pin has no input path at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Combinational read data |
| pad_in | input | NB+1 | Raw pad inputs (bidirectional pins and input-only pin) |
| pad_out | output | NB+2 | Output value to each pad |
| pad_oe | output | NB+2 | Output driver enable for each pad |
| pad_pull | output | NB+2 | Pull device enable for each pad |
| periph_en | input | NB | Digital peripheral owns the pin |
| periph_oe | input | NB | Peripheral output enable |
| periph_out | input | NB | Peripheral output data |
| analog_en | input | NB | Analog function owns the pin |
| dbg_oe | input | 1 | Debug/mode function output enable for the output-only pin |
| dbg_out | input | 1 | Debug/mode function output data for the output-only pin |
| pin_in | output | NB+1 | Synchronized, gated pin inputs for peripherals |

## Verification
The hardest case to reach is a read-source mix in which some pins read their latch and others read their pads, while those pads sit at values that differ from the latch. A data read can only tell the two sources apart under those conditions. The bench therefore holds a fixed latch pattern and sweeps every direction mask against every pad pattern, and it waits out the synchronizer before each read. The priority order gets the same treatment: all analog masks are applied while a peripheral claims every pin, and all peripheral masks are crossed with all peripheral enable patterns.

// File: rtl/sharedpin_port_pkg.sv
package sharedpin_port_pkg;

    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_DIR  = 2'd1,
        REG_PULL = 2'd2,
        REG_CTRL = 2'd3
    } reg_sel_e;

    typedef enum logic {
        OO_DEBUG = 1'b0,
        OO_PORT  = 1'b1
    } oo_state_e;

endpackage

// File: rtl/sharedpin_sync.sv
module sharedpin_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg_q[k] <= '0;
        end else begin
            stg_q[0] <= d;
            for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/sharedpin_oo_fsm.sv
module sharedpin_oo_fsm
    import sharedpin_port_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ctrl_we,
    input  logic      claim,
    output oo_state_e state,
    output logic      port_own
);
    oo_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OO_DEBUG;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OO_DEBUG: if (ctrl_we && claim)  state_d = OO_PORT;
            OO_PORT:  if (ctrl_we && !claim) state_d = OO_DEBUG;
        endcase
    end

    always_comb begin
        state    = state_q;
        port_own = (state_q == OO_PORT);
    end
endmodule

// File: rtl/sharedpin_regs.sv
module sharedpin_regs
    import sharedpin_port_pkg::*;
#(
    parameter int NB = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  reg_sel_e      addr,
    input  logic [DW-1:0] wdata,
    input  logic [NB:0]   sync_in,
    input  logic [NB-1:0] analog_en,
    input  logic          port_own,
    output logic [NB-1:0] dir_q,
    output logic [NB-1:0] lat_q,
    output logic          lat_oo_q,
    output logic [NB:0]   pull_q,
    output logic [DW-1:0] rdata
);
    localparam int IN_BIT = NB;
    localparam int OO_BIT = NB + 1;

    logic wdata_unused;
    assign wdata_unused = ^wdata[DW-1:OO_BIT+1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q    <= '0;
            lat_q    <= '0;
            lat_oo_q <= 1'b0;
            pull_q   <= '0;
        end else if (we) begin
            unique case (addr)
                REG_DATA: begin
                    lat_q    <= wdata[NB-1:0];
                    lat_oo_q <= wdata[OO_BIT];
                end
                REG_DIR:  dir_q  <= wdata[NB-1:0];
                REG_PULL: pull_q <= wdata[IN_BIT:0];
                REG_CTRL: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            REG_DATA: begin
                rdata[NB-1:0] = ((dir_q & lat_q) | (~dir_q & sync_in[NB-1:0])) & ~analog_en;
                rdata[IN_BIT] = sync_in[IN_BIT];
                rdata[OO_BIT] = lat_oo_q;
            end
            REG_DIR: begin
                rdata[NB-1:0] = dir_q;
                rdata[IN_BIT] = 1'b0;
                rdata[OO_BIT] = 1'b1;
            end
            REG_PULL: rdata[IN_BIT:0] = pull_q;
            REG_CTRL: rdata[0] = port_own;
        endcase
    end
endmodule

// File: rtl/sharedpin_pinmux.sv
module sharedpin_pinmux
    import sharedpin_port_pkg::*;
#(
    parameter int NB = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] dir_q,
    input  logic [NB-1:0] lat_q,
    input  logic          lat_oo_q,
    input  logic [NB:0]   pull_q,
    input  logic [NB:0]   sync_q,
    input  logic [NB-1:0] periph_en,
    input  logic [NB-1:0] periph_oe,
    input  logic [NB-1:0] periph_out,
    input  logic [NB-1:0] analog_en,
    input  oo_state_e     oo_state,
    input  logic          dbg_oe,
    input  logic          dbg_out,
    output logic [NB+1:0] pad_out,
    output logic [NB+1:0] pad_oe,
    output logic [NB+1:0] pad_pull,
    output logic [NB:0]   pin_in
);
    localparam int IN_BIT = NB;
    localparam int OO_BIT = NB + 1;

    logic clk_unused;
    assign clk_unused = clk ^ rst_n;

    for (genvar i = 0; i < NB; i++) begin : g_bidir
        logic oe_b, out_b;
        always_comb begin
            if (analog_en[i]) begin
                oe_b  = 1'b0;
                out_b = 1'b0;
            end else if (periph_en[i]) begin
                oe_b  = periph_oe[i];
                out_b = periph_out[i];
            end else begin
                oe_b  = dir_q[i];
                out_b = lat_q[i];
            end
        end
        assign pad_oe[i]   = oe_b;
        assign pad_out[i]  = out_b;
        assign pad_pull[i] = pull_q[i] & ~oe_b & ~analog_en[i];
        assign pin_in[i]   = sync_q[i] & ~analog_en[i];
    end

    assign pad_oe[IN_BIT]   = 1'b0;
    assign pad_out[IN_BIT]  = 1'b0;
    assign pad_pull[IN_BIT] = pull_q[IN_BIT];
    assign pin_in[IN_BIT]   = sync_q[IN_BIT];

    logic oo_oe, oo_out;
    always_comb begin
        unique case (oo_state)
            OO_DEBUG: begin
                oo_oe  = dbg_oe;
                oo_out = dbg_out;
            end
            OO_PORT: begin
                oo_oe  = 1'b1;
                oo_out = lat_oo_q;
            end
        endcase
    end
    assign pad_oe[OO_BIT]   = oo_oe;
    assign pad_out[OO_BIT]  = oo_out;
    assign pad_pull[OO_BIT] = 1'b0;
endmodule

// File: rtl/sharedpin_port.sv
module sharedpin_port
    import sharedpin_port_pkg::*;
#(
    parameter int NB          = 4,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_we,
    input  logic [1:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [NB:0]   pad_in,
    output logic [NB+1:0] pad_out,
    output logic [NB+1:0] pad_oe,
    output logic [NB+1:0] pad_pull,
    input  logic [NB-1:0] periph_en,
    input  logic [NB-1:0] periph_oe,
    input  logic [NB-1:0] periph_out,
    input  logic [NB-1:0] analog_en,
    input  logic          dbg_oe,
    input  logic          dbg_out,
    output logic [NB:0]   pin_in
);
    localparam int SENSE_W = NB + 1;

    reg_sel_e      addr_sel;
    oo_state_e     oo_state;
    logic          port_own;
    logic [NB:0]   sync_q;
    logic [NB-1:0] dir_q, lat_q;
    logic          lat_oo_q;
    logic [NB:0]   pull_q;

    assign addr_sel = reg_sel_e'(bus_addr);

    sharedpin_sync #(.W(SENSE_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (sync_q)
    );

    sharedpin_oo_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_we  (bus_we && (addr_sel == REG_CTRL)),
        .claim    (bus_wdata[0]),
        .state    (oo_state),
        .port_own (port_own)
    );

    sharedpin_regs #(.NB(NB), .DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (bus_we),
        .addr      (addr_sel),
        .wdata     (bus_wdata),
        .sync_in   (sync_q),
        .analog_en (analog_en),
        .port_own  (port_own),
        .dir_q     (dir_q),
        .lat_q     (lat_q),
        .lat_oo_q  (lat_oo_q),
        .pull_q    (pull_q),
        .rdata     (bus_rdata)
    );

    sharedpin_pinmux #(.NB(NB)) u_mux (
        .clk        (clk),
        .rst_n      (rst_n),
        .dir_q      (dir_q),
        .lat_q      (lat_q),
        .lat_oo_q   (lat_oo_q),
        .pull_q     (pull_q),
        .sync_q     (sync_q),
        .periph_en  (periph_en),
        .periph_oe  (periph_oe),
        .periph_out (periph_out),
        .analog_en  (analog_en),
        .oo_state   (oo_state),
        .dbg_oe     (dbg_oe),
        .dbg_out    (dbg_out),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe),
        .pad_pull   (pad_pull),
        .pin_in     (pin_in)
    );
endmodule

// File: rtl/sharedpin_port_chk.sv
module sharedpin_port_chk
    import sharedpin_port_pkg::*;
#(
    parameter int NB = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NB:0]   pad_in,
    input logic [NB+1:0] pad_oe,
    input logic [NB+1:0] pad_pull,
    input logic [NB:0]   pin_in,
    input logic [NB-1:0] periph_en,
    input logic [NB-1:0] periph_oe,
    input logic [NB-1:0] analog_en,
    input oo_state_e     oo_state
);
    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              age_q <= '0;
        else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (oo_state == OO_DEBUG && pad_pull == '0));

    // R4
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2) |-> (pin_in[NB] == $past(pad_in[NB], 2)));

    // R6
    periph_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe[NB-1:0] ^ periph_oe) & periph_en & ~analog_en) == '0);

    // R7
    analog_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_in[NB-1:0] | pad_oe[NB-1:0] | pad_pull[NB-1:0]) & analog_en) == '0);

    // R8
    inonly_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pad_oe[NB]);

    // R9
    oo_port_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oo_state == OO_PORT) |-> pad_oe[NB+1]);

    // R10
    pull_vs_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pull & pad_oe) == '0);
endmodule

bind sharedpin_port sharedpin_port_chk #(.NB(NB)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pad_in    (pad_in),
    .pad_oe    (pad_oe),
    .pad_pull  (pad_pull),
    .pin_in    (pin_in),
    .periph_en (periph_en),
    .periph_oe (periph_oe),
    .analog_en (analog_en),
    .oo_state  (oo_state)
);

// File: tb/tb_sharedpin_port.sv
module tb_sharedpin_port;
    localparam int NB = 4;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0;
    logic [1:0]    bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [NB:0]   pad_in = '0;
    logic [NB+1:0] pad_out, pad_oe, pad_pull;
    logic [NB-1:0] periph_en = '0, periph_oe = '0, periph_out = '0, analog_en = '0;
    logic          dbg_oe = 1'b0, dbg_out = 1'b0;
    logic [NB:0]   pin_in;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    sharedpin_port #(.NB(NB), .DW(DW), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull(pad_pull),
        .periph_en(periph_en), .periph_oe(periph_oe), .periph_out(periph_out),
        .analog_en(analog_en), .dbg_oe(dbg_oe), .dbg_out(dbg_out), .pin_in(pin_in)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] r;
        int exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(1, r); check(r == 8'h20, "R1 dir", r, 8'h20);
        rd(2, r); check(r == 8'h00, "R1 pull", r, 0);
        rd(3, r); check(r == 8'h00, "R1 ctrl", r, 0);
        check(pad_oe[4:0] == 0, "R1 oe", pad_oe[4:0], 0);
        check(pad_pull == 0, "R1 pad_pull", pad_pull, 0);

        // R8 fixed direction bits
        wr(1, 8'hFF); rd(1, r); check(r == 8'h2F, "R8 dir all", r, 8'h2F);
        check(pad_oe[4] == 1'b0, "R8 inonly oe", pad_oe[4], 0);
        wr(1, 8'h00); rd(1, r); check(r == 8'h20, "R8 dir none", r, 8'h20);

        // R5 / R2 latch written as input, then driven
        for (int v = 0; v < 16; v++) begin
            wr(0, 8'(v));
            check(pad_oe[3:0] == 0, "R5 still input", pad_oe[3:0], 0);
            rd(0, r); check(r[3:0] == 0, "R5 read pad", r[3:0], 0);
            wr(1, 8'h0F);
            check(pad_oe[3:0] == 4'hF, "R2 oe", pad_oe[3:0], 4'hF);
            check(pad_out[3:0] == 4'(v), "R5 drives latch", pad_out[3:0], v);
            rd(0, r); check(r[3:0] == 4'(v), "R2 read latch", r[3:0], v);
            wr(1, 8'h00);
        end

        // R3 read source mux sweep
        wr(0, 8'h05);
        for (int d = 0; d < 16; d++) begin
            wr(1, 8'(d));
            for (int p = 0; p < 32; p++) begin
                @(negedge clk); pad_in = 5'(p);
                @(negedge clk); @(negedge clk);
                rd(0, r);
                exp = (((d & 5) | (~d & p)) & 15) | (p & 16);
                check(r == 8'(exp), "R3 data mux", r, exp);
            end
        end
        wr(1, 8'h00);

        // R4 synchronizer latency
        for (int p = 0; p < 32; p++) begin
            @(negedge clk); pad_in = 5'(p);
            @(negedge clk); @(negedge clk); @(negedge clk);
            pad_in = ~5'(p);
            @(negedge clk);
            rd(0, r); check(r[4:0] == 5'(p), "R4 one edge old", r[4:0], p);
            check(pin_in == 5'(p), "R4 pin_in one edge", pin_in, p);
            @(negedge clk);
            rd(0, r); check(r[4:0] == ~5'(p), "R4 two edges new", r[4:0], 5'(~p));
        end

        // R6 peripheral override
        wr(1, 8'h0F); wr(0, 8'h0A);
        for (int en = 0; en < 16; en++) begin
            for (int v = 0; v < 16; v++) begin
                periph_en = 4'(en); periph_oe = 4'(v); periph_out = ~4'(v);
                #1;
                exp = ((en & v) | (~en & 15)) & 15;
                check(pad_oe[3:0] == 4'(exp), "R6 oe", pad_oe[3:0], exp);
                exp = ((en & ~v) | (~en & 10)) & 15;
                check(pad_out[3:0] == 4'(exp), "R6 out", pad_out[3:0], exp);
            end
        end
        periph_en = 4'hF; periph_oe = 4'h3; periph_out = 4'h6;
        wr(0, 8'h05);
        check(pad_out[3:0] == 4'h6, "R6 write ignored", pad_out[3:0], 6);
        check(pad_oe[3:0] == 4'h3, "R6 oe ignores dir", pad_oe[3:0], 3);
        rd(0, r); check(r[3:0] == 4'h5, "R6 latch kept", r[3:0], 5);

        // R7 analog ownership beats peripheral
        periph_oe = 4'hF;
        wr(2, 8'h1F); wr(0, 8'h0F);
        @(negedge clk); pad_in = 5'h1F; @(negedge clk); @(negedge clk);
        for (int a = 0; a < 16; a++) begin
            analog_en = 4'(a); #1;
            exp = ~a & 15;
            check(pad_oe[3:0] == 4'(exp), "R7 oe", pad_oe[3:0], exp);
            check(pin_in == 5'(exp | 16), "R7 pin_in", pin_in, exp | 16);
            rd(0, r); check(r[4:0] == 5'(exp | 16), "R7 read", r[4:0], exp | 16);
        end
        periph_en = 4'h0;
        wr(1, 8'h00);
        for (int a = 0; a < 16; a++) begin
            analog_en = 4'(a); #1;
            exp = (~a & 15) | 16;
            check(pad_pull[4:0] == 5'(exp), "R7 pull", pad_pull[4:0], exp);
        end
        analog_en = 4'h0;

        // R10 pull gating
        wr(2, 8'hFF); rd(2, r); check(r == 8'h1F, "R10 oo pull fixed", r, 8'h1F);
        for (int d = 0; d < 16; d++) begin
            wr(1, 8'(d));
            exp = (~d & 15) | 16;
            check(pad_pull == 6'(exp), "R10 pull", pad_pull, exp);
        end
        wr(1, 8'h00);
        periph_en = 4'hF; periph_oe = 4'h3; #1;
        check(pad_pull == 6'h1C, "R10 periph drive", pad_pull, 8'h1C);
        periph_en = 4'h0;

        // R9 output-only pin ownership
        for (int k = 0; k < 4; k++) begin
            dbg_oe = k[1]; dbg_out = k[0]; #1;
            check(pad_oe[5] == k[1] && pad_out[5] == k[0], "R9 debug follows",
                  {pad_oe[5], pad_out[5]}, k);
        end
        wr(0, 8'h20);
        check(pad_out[5] == dbg_out, "R9 latch hidden", pad_out[5], dbg_out);
        wr(3, 8'h01); rd(3, r); check(r == 8'h01, "R9 claim", r, 1);
        rd(0, r); check(r[5] == 1'b1, "R9 oo read latch", r[5], 1);
        for (int k = 0; k < 4; k++) begin
            dbg_oe = k[1]; dbg_out = k[0]; #1;
            check(pad_oe[5] == 1'b1 && pad_out[5] == 1'b1, "R9 port drives",
                  {pad_oe[5], pad_out[5]}, 3);
        end
        wr(0, 8'h00); check(pad_out[5] == 1'b0, "R9 port latch 0", pad_out[5], 0);
        wr(3, 8'h01); rd(3, r); check(r == 8'h01, "R9 hold", r, 1);
        dbg_oe = 1'b0; dbg_out = 1'b1;
        wr(3, 8'h00); rd(3, r); check(r == 8'h00, "R9 release", r, 0);
        check(pad_oe[5] == 1'b0 && pad_out[5] == 1'b1, "R9 back to debug",
              {pad_oe[5], pad_out[5]}, 1);

        // R11 peripheral input path
        @(negedge clk); pad_in = 5'h15; @(negedge clk); @(negedge clk);
        check(pin_in == 5'h15, "R11 pin_in", pin_in, 8'h15);
        rd(0, r); check(r[7:6] == 2'b00, "R11 unused bits", r[7:6], 0);

        finish_run();
    end
endmodule